// File: doc/BRIEF.md
# Domain-Based Access Permission Checker

This block makes the final allow-or-refuse decision for a memory access whose address has already been translated. The matching translation entry supplies a 4-bit domain number and its permission fields (access-permission code, privileged-only flag, execute-never flag). The requester supplies the kind of access (read, write or instruction fetch) and whether the processor is in privileged or user mode. The block answers with exactly one of three verdicts: grant, domain fault or permission fault.

A 32-bit domain control register holds a 2-bit mode for each of the 16 domains. A domain can be in one of three modes. With no access, every access to it is refused with a domain fault. In client mode, the entry's own permission fields are enforced. In manager mode, those fields are skipped and the access is granted. Software writes the register through a write-enable port and can read its current value back at any time. The verdict is registered: it appears one clock after the request is presented.

Top module: `dom_acc_checker`

## Requirements
- R1: After reset, `dcr_rdata` is zero and `res_valid`, `res_grant`, `res_dom_fault` and `res_perm_fault` are all low.
- R2: When `dcr_we` is high at a clock edge, `dcr_rdata` shows `dcr_wdata` from the next cycle on. When `dcr_we` is low, the register keeps its value.
- R3: The mode of domain d is register bits [2d+1:2d], coded as 00 no access, 01 client, 11 manager and 10 reserved. A domain coded 00 or 10 gives a domain fault whatever the entry fields, access kind or privilege are.
- R4: A manager domain (11) grants every access, whatever the access-permission code, privileged-only flag, execute-never flag, access kind or privilege.
- R5: In a client domain the access-permission code `chk_ap` is enforced. Code 00 refuses every access. Code 01 is read only: reads and fetches may pass, writes are refused. Code 10 is read-write. Code 11 is reserved and refuses every access. The access kind `chk_kind` is coded 00 read, 01 write, 10 fetch, and 11 is also treated as a fetch. A refusal is a permission fault.
- R6: In a client domain, an entry with `chk_priv_only` = 1 refuses a user-mode access (`chk_priv` = 0) with a permission fault. A privileged access to such an entry follows R5.
- R7: In a client domain, an entry with `chk_xn` = 1 refuses an instruction fetch with a permission fault. Reads and writes are not affected by this flag.
- R8: The verdict for a request with `chk_valid` high appears one cycle later with `res_valid` high and exactly one of grant, domain fault and permission fault set. When no request was made, `res_valid` and all three verdict outputs are low.
- R9: A domain fault takes priority over any permission failure the entry would cause.
- R10: The domain used for the check is the one named by `chk_domain`. The modes of all other domains have no effect.
- R11: A request presented in the same cycle as a register write is checked against the register value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dcr_we | input | 1 | Domain control register write enable |
| dcr_wdata | input | 32 | Domain control register write value |
| dcr_rdata | output | 32 | Domain control register current value |
| chk_valid | input | 1 | Access request present |
| chk_domain | input | 4 | Domain number from the translation entry |
| chk_ap | input | 2 | Access-permission code from the entry |
| chk_priv_only | input | 1 | Entry restricted to privileged mode |
| chk_xn | input | 1 | Entry is execute-never |
| chk_kind | input | 2 | Access kind: 00 read, 01 write, 1x fetch |
| chk_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| res_valid | output | 1 | Verdict present (one cycle after request) |
| res_grant | output | 1 | Access granted |
| res_dom_fault | output | 1 | Refused by domain mode |
| res_perm_fault | output | 1 | Refused by entry permissions |

## Verification
The bench sweeps every domain through all four mode codes. While it does so, the other fifteen domains hold a mode that gives the opposite verdict, so a design that indexes the wrong register field, or reverses the field order, returns the wrong verdict. For each setting the bench tries every combination of permission code, privileged-only flag, execute-never flag, access kind and privilege. This catches several kinds of error:
- A design that decodes the reserved mode 10 as client or manager grants accesses where a domain fault is expected.
- A design that lets a manager domain honour execute-never or privileged-only refuses accesses that should be granted.
- A design that treats the reserved permission code 11 as read-write grants accesses that should fault.

Separate checks issue a request in the same cycle as a register write, so that a design that bypasses the new value into the check shows up. Further checks confirm that writes made with the enable low leave the register unchanged.

// File: rtl/dac_pkg.sv
package dac_pkg;

  typedef enum logic [1:0] {
    DM_NONE   = 2'b00,
    DM_CLIENT = 2'b01,
    DM_RSVD   = 2'b10,
    DM_MGR    = 2'b11
  } dom_mode_e;

  typedef enum logic [1:0] {
    AK_READ  = 2'b00,
    AK_WRITE = 2'b01,
    AK_FETCH = 2'b10,
    AK_FETCH2 = 2'b11
  } acc_kind_e;

  localparam logic [1:0] AP_NONE = 2'b00;
  localparam logic [1:0] AP_RO   = 2'b01;
  localparam logic [1:0] AP_RW   = 2'b10;
  localparam logic [1:0] AP_RSVD = 2'b11;

endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/dac_dom_reg.sv
module dac_dom_reg
  import dac_pkg::*;
#(
  parameter int NUM_DOM = 16,
  localparam int DOM_W = $clog2(NUM_DOM),
  localparam int DCR_W = 2 * NUM_DOM
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [DCR_W-1:0] wdata,
  output logic [DCR_W-1:0] rdata,
  input  logic [DOM_W-1:0] sel,
  output dom_mode_e        sel_mode
);
  logic [DCR_W-1:0] dcr_q;
  logic [DCR_W-1:0] dcr_d;
  logic [1:0]       mode_arr [NUM_DOM];

  always_comb begin
    dcr_d = dcr_q;
    if (we) dcr_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dcr_q <= '0;
    else        dcr_q <= dcr_d;
  end

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_mode
    assign mode_arr[g] = dcr_q[2*g +: 2];
  end

  assign sel_mode = dom_mode_e'(mode_arr[sel]);
  assign rdata    = dcr_q;

  // R2: a write shows up on the read port one cycle later
  assert_dcr_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(we) && $past(rst_n)) |-> (rdata == $past(wdata)));

  // R2: without the enable the register holds
  assert_dcr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(rdata));
endmodule

// File: rtl/dac_perm_eval.sv
module dac_perm_eval
  import dac_pkg::*;
(
  input  dom_mode_e  mode,
  input  logic [1:0] ap,
  input  logic       priv_only,
  input  logic       xn,
  input  acc_kind_e  kind,
  input  logic       priv,
  output logic       grant,
  output logic       dom_fault,
  output logic       perm_fault
);
  logic is_write;
  logic is_fetch;
  logic entry_ok;

  always_comb begin
    is_write = (kind == AK_WRITE);
    is_fetch = (kind == AK_FETCH) || (kind == AK_FETCH2);
    entry_ok = 1'b1;
    if (ap == AP_NONE || ap == AP_RSVD) entry_ok = 1'b0;
    if (ap == AP_RO && is_write)        entry_ok = 1'b0;
    if (priv_only && !priv)             entry_ok = 1'b0;
    if (xn && is_fetch)                 entry_ok = 1'b0;

    grant      = 1'b0;
    dom_fault  = 1'b0;
    perm_fault = 1'b0;
    unique case (mode)
      DM_NONE, DM_RSVD: dom_fault = 1'b1;
      DM_MGR:           grant     = 1'b1;
      DM_CLIENT: begin
        grant      = entry_ok;
        perm_fault = !entry_ok;
      end
      default:          dom_fault = 1'b1;
    endcase
  end
endmodule

// File: rtl/dom_acc_checker.sv
module dom_acc_checker
  import dac_pkg::*;
#(
  parameter int NUM_DOM = 16,
  localparam int DOM_W = $clog2(NUM_DOM),
  localparam int DCR_W = 2 * NUM_DOM
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dcr_we,
  input  logic [DCR_W-1:0] dcr_wdata,
  output logic [DCR_W-1:0] dcr_rdata,
  input  logic             chk_valid,
  input  logic [DOM_W-1:0] chk_domain,
  input  logic [1:0]       chk_ap,
  input  logic             chk_priv_only,
  input  logic             chk_xn,
  input  logic [1:0]       chk_kind,
  input  logic             chk_priv,
  output logic             res_valid,
  output logic             res_grant,
  output logic             res_dom_fault,
  output logic             res_perm_fault
);
  logic      rst_n_s;
  dom_mode_e cur_mode;
  logic      e_grant, e_dfault, e_pfault;
  logic      valid_d, grant_d, dfault_d, pfault_d;

  dac_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  dac_dom_reg #(.NUM_DOM(NUM_DOM)) u_dreg (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .we       (dcr_we),
    .wdata    (dcr_wdata),
    .rdata    (dcr_rdata),
    .sel      (chk_domain),
    .sel_mode (cur_mode)
  );

  dac_perm_eval u_eval (
    .mode       (cur_mode),
    .ap         (chk_ap),
    .priv_only  (chk_priv_only),
    .xn         (chk_xn),
    .kind       (acc_kind_e'(chk_kind)),
    .priv       (chk_priv),
    .grant      (e_grant),
    .dom_fault  (e_dfault),
    .perm_fault (e_pfault)
  );

  always_comb begin
    valid_d  = chk_valid;
    grant_d  = chk_valid & e_grant;
    dfault_d = chk_valid & e_dfault;
    pfault_d = chk_valid & e_pfault;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      res_valid      <= 1'b0;
      res_grant      <= 1'b0;
      res_dom_fault  <= 1'b0;
      res_perm_fault <= 1'b0;
    end else begin
      res_valid      <= valid_d;
      res_grant      <= grant_d;
      res_dom_fault  <= dfault_d;
      res_perm_fault <= pfault_d;
    end
  end

  // R8: one verdict per result, none when idle
  assert_one_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    res_valid |-> ($countones({res_grant, res_dom_fault, res_perm_fault}) == 1));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !res_valid |-> ({res_grant, res_dom_fault, res_perm_fault} == 3'b000));

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    chk_valid |=> res_valid);

  // R4: a manager domain always grants
  assert_mgr_grant_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (chk_valid && cur_mode == DM_MGR) |=> res_grant);

  // R3 / R9: no-access and reserved modes give a domain fault
  assert_dom_fault_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (chk_valid && (cur_mode == DM_NONE || cur_mode == DM_RSVD)) |=> res_dom_fault);
endmodule

// File: tb/dom_acc_checker_tb_top.sv
module dom_acc_checker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dcr_we = 1'b0;
  logic [31:0] dcr_wdata = '0;
  logic [31:0] dcr_rdata;
  logic        chk_valid = 1'b0;
  logic [3:0]  chk_domain = '0;
  logic [1:0]  chk_ap = '0;
  logic        chk_priv_only = 1'b0;
  logic        chk_xn = 1'b0;
  logic [1:0]  chk_kind = '0;
  logic        chk_priv = 1'b0;
  logic        res_valid, res_grant, res_dom_fault, res_perm_fault;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dom_acc_checker dut_i (
    .clk(clk), .rst_n(rst_n),
    .dcr_we(dcr_we), .dcr_wdata(dcr_wdata), .dcr_rdata(dcr_rdata),
    .chk_valid(chk_valid), .chk_domain(chk_domain), .chk_ap(chk_ap),
    .chk_priv_only(chk_priv_only), .chk_xn(chk_xn), .chk_kind(chk_kind),
    .chk_priv(chk_priv),
    .res_valid(res_valid), .res_grant(res_grant),
    .res_dom_fault(res_dom_fault), .res_perm_fault(res_perm_fault)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // verdict vector {valid, grant, dom_fault, perm_fault}
  function automatic logic [3:0] expect_v(input logic [1:0] mode, input logic [1:0] ap,
      input logic po, input logic xn, input logic [1:0] kind, input logic priv);
    logic ok;
    if (mode == 2'b00 || mode == 2'b10) return 4'b1010;
    if (mode == 2'b11) return 4'b1100;
    ok = 1'b1;
    if (ap == 2'b00 || ap == 2'b11) ok = 1'b0;
    if (ap == 2'b01 && kind == 2'b01) ok = 1'b0;
    if (po && !priv) ok = 1'b0;
    if (kind[1] && xn) ok = 1'b0;
    return ok ? 4'b1100 : 4'b1001;
  endfunction

  task automatic check_eq(input string lab, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", lab, act, exp);
    end
  endtask

  task automatic write_dcr(input logic [31:0] v);
    @(negedge clk);
    dcr_we = 1'b1;
    dcr_wdata = v;
    @(negedge clk);
    dcr_we = 1'b0;
  endtask

  task automatic run_chk(input logic [3:0] d, input logic [1:0] ap, input logic po,
      input logic xn, input logic [1:0] kind, input logic priv, input logic [3:0] exp,
      input string lab);
    @(negedge clk);
    chk_valid = 1'b1; chk_domain = d; chk_ap = ap; chk_priv_only = po;
    chk_xn = xn; chk_kind = kind; chk_priv = priv;
    @(negedge clk);
    chk_valid = 1'b0;
    check_eq(lab, {28'd0, res_valid, res_grant, res_dom_fault, res_perm_fault}, {28'd0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check_eq("R1 rdata", dcr_rdata, 32'h0);
    check_eq("R1 verdict", {28'd0, res_valid, res_grant, res_dom_fault, res_perm_fault}, 32'h0);

    // R2: write, then writes with enable low are ignored
    write_dcr(32'hA5C3_0F96);
    check_eq("R2 write", dcr_rdata, 32'hA5C3_0F96);
    @(negedge clk);
    dcr_wdata = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check_eq("R2 hold", dcr_rdata, 32'hA5C3_0F96);

    // R8: idle cycle yields no verdict
    @(negedge clk);
    check_eq("R8 idle", {28'd0, res_valid, res_grant, res_dom_fault, res_perm_fault}, 32'h0);

    // R11: same-cycle write does not affect the check in that cycle
    write_dcr(32'hFFFF_FFFF);
    @(negedge clk);
    chk_valid = 1'b1; chk_domain = 4'd5; chk_ap = 2'b00; chk_priv_only = 1'b1;
    chk_xn = 1'b1; chk_kind = 2'b10; chk_priv = 1'b0;
    dcr_we = 1'b1; dcr_wdata = 32'h0;
    @(negedge clk);
    chk_valid = 1'b0; dcr_we = 1'b0;
    check_eq("R11 old mode used", {28'd0, res_valid, res_grant, res_dom_fault, res_perm_fault},
             32'hC);
    run_chk(4'd5, 2'b10, 1'b0, 1'b0, 2'b00, 1'b1, 4'b1010, "R11 new mode after write");

    // Exhaustive sweep: R3 R4 R5 R6 R7 R9 R10
    for (int d = 0; d < 16; d++) begin
      for (int m = 0; m < 4; m++) begin
        logic [31:0] v;
        v = (m == 3) ? 32'h0 : 32'hFFFF_FFFF;
        v[2*d +: 2] = m[1:0];
        write_dcr(v);
        for (int a = 0; a < 4; a++)
          for (int p = 0; p < 2; p++)
            for (int x = 0; x < 2; x++)
              for (int k = 0; k < 4; k++)
                for (int pr = 0; pr < 2; pr++) begin
                  string lab;
                  logic [3:0] e;
                  e = expect_v(m[1:0], a[1:0], p[0], x[0], k[1:0], pr[0]);
                  if (m == 0 || m == 2)        lab = "R3 R9 R10";
                  else if (m == 3)             lab = "R4 R10";
                  else if (k[1] && x[0])       lab = "R7 R10";
                  else if (p[0] && !pr[0])     lab = "R6 R10";
                  else                         lab = "R5 R10";
                  run_chk(d[3:0], a[1:0], p[0], x[0], k[1:0], pr[0], e,
                          $sformatf("%s d=%0d m=%0d ap=%0d po=%0d xn=%0d k=%0d pr=%0d",
                                    lab, d, m, a, p, x, k, pr));
                end
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule